// File: doc/BRIEF.md
# Reference-Locked Transport Stream Error Detector

This block measures bit errors on a byte-wide transport stream whose content repeats packet after packet, such as a stuffing pattern sent through a scrambling modulator and a receiver under test. It does not generate the expected pattern locally. Instead it learns the pattern from the stream. It hunts for the 0x47 sync byte and writes the packet that starts there into a reference memory. It then uses that packet as the reference only after the next packet matches it exactly.

Once locked, the block XORs every accepted byte with the stored byte at the same packet offset. It adds eight to a bit counter and adds the number of differing bits to an error counter. It also outputs the XOR mask and the packet offset of each byte so that downstream logic can analyse where errors fall. Lock is dropped when the sync byte is absent at packet start for three packets in a row, which is what happens when the upstream clock slips. Counting then pauses until a fresh reference has been learned and confirmed.

Top module: `ts_ref_error_detector`

## Requirements
- R1: A capture starts on a valid byte equal to 0x47 while hunting. That byte is stored at offset 0, and the following PKT_LEN-1 valid bytes (PKT_LEN is 188 or 204) fill offsets 1 to PKT_LEN-1.
- R2: `locked` rises after the last byte of the packet that follows the captured candidate, and only if every byte of that packet equals the stored byte at the same offset. Any mismatch discards the candidate and returns the block to hunting.
- R3: Each valid byte accepted while `locked` is 1 adds 8 to `bit_cnt`.
- R4: Each such byte adds the population count (0 to 8) of `din` XOR the stored byte at its offset to `err_cnt`.
- R5: `err_mask` (the XOR result), `err_off` (the byte's packet offset) and `err_vld` are registered. They are visible after the clock edge that accepts the byte. `err_vld` is 0 for cycles with no counted byte, and `err_mask` is then 0.
- R6: Bytes received while not locked, including the candidate and the confirming packet, leave both counters unchanged.
- R7: While locked, a byte other than 0x47 at offset 0 counts as a missing sync. The third consecutive missing sync clears `locked`. A correct sync resets the run. Missing-sync bytes received while still locked are counted like any other byte.
- R8: After lock is lost, the counters hold their values, and counting resumes only after a new capture and confirmation as in R1 and R2.
- R9: `clr` high on a clock edge zeroes both counters. It takes priority over a byte accepted in the same cycle.
- R10: Both counters saturate at all ones instead of wrapping.
- R11: A cycle with `din_vld` low is ignored. It does not advance the offset and does not touch the counters or the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of both counters |
| din | input | 8 | Received stream byte |
| din_vld | input | 1 | Byte strobe for `din` |
| locked | output | 1 | Reference confirmed and comparison running |
| bit_cnt | output | CNT_W (48) | Bits compared, saturating |
| err_cnt | output | CNT_W (48) | Bit errors found, saturating |
| err_mask | output | 8 | XOR of the last counted byte with its reference |
| err_vld | output | 1 | `err_mask` and `err_off` describe a counted byte |
| err_off | output | $clog2(PKT_LEN) (8) | Packet offset of the last counted byte |

## Verification
All results are registered once. A byte driven on a falling edge is taken on the next rising edge, and its effect on `locked`, the counters and the error mask is visible from that edge on. The bench therefore drives on falling edges and, after the byte of interest, idles `din_vld` for one falling edge and samples there. Lock rise, lock loss, counter values, clearing and saturation are all sampled at that point. Mask and offset are checked in an idle gap inserted right after the corrupted byte, before the following byte can overwrite them.

// File: rtl/ts_ref_error_detector.sv
module ts_ref_error_detector #(
  parameter int          PKT_LEN    = 188,
  parameter int          CNT_W      = 48,
  parameter int          MISS_LIMIT = 3,
  parameter logic [7:0]  SYNC_BYTE  = 8'h47,
  localparam int         OFF_W      = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [7:0]       din,
  input  logic             din_vld,
  output logic             locked,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic [7:0]       err_mask,
  output logic             err_vld,
  output logic [OFF_W-1:0] err_off
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  typedef enum logic [1:0] {HUNT, CAPTURE, VERIFY, LOCK} state_t;

  state_t            st;
  logic [7:0]        ref_mem [PKT_LEN];
  logic [OFF_W-1:0]  off;
  logic [MISS_W-1:0] miss;

  wire              last   = (off == OFF_W'(PKT_LEN - 1));
  wire [OFF_W-1:0]  off_nx = last ? '0 : off + 1'b1;
  wire [7:0]        diff   = din ^ ref_mem[off];
  wire              acc    = din_vld && (st == LOCK);
  wire              wr     = din_vld && ((st == HUNT && din == SYNC_BYTE) || st == CAPTURE);
  wire [3:0]        pop    = 4'($countones(diff));
  wire [CNT_W:0]    bsum   = {1'b0, bit_cnt} + (CNT_W+1)'(8);
  wire [CNT_W:0]    esum   = {1'b0, err_cnt} + (CNT_W+1)'(pop);

  assign locked = (st == LOCK);

  always_ff @(posedge clk)
    if (wr) ref_mem[off] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= HUNT;
      off  <= '0;
      miss <= '0;
    end else if (din_vld) begin
      case (st)
        HUNT:
          if (din == SYNC_BYTE) begin
            st  <= CAPTURE;
            off <= OFF_W'(1);
          end
        CAPTURE: begin
          off <= off_nx;
          if (last) st <= VERIFY;
        end
        VERIFY:
          if (diff != 8'h00) begin
            st  <= HUNT;
            off <= '0;
          end else begin
            off <= off_nx;
            if (last) begin
              st   <= LOCK;
              miss <= '0;
            end
          end
        LOCK: begin
          off <= off_nx;
          if (off == '0) begin
            if (din == SYNC_BYTE) begin
              miss <= '0;
            end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
              st   <= HUNT;
              off  <= '0;
              miss <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (acc) begin
      bit_cnt <= bsum[CNT_W] ? '1 : bsum[CNT_W-1:0];
      err_cnt <= esum[CNT_W] ? '1 : esum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_mask <= '0;
      err_vld  <= 1'b0;
      err_off  <= '0;
    end else begin
      err_vld  <= acc;
      err_mask <= acc ? diff : 8'h00;
      if (acc) err_off <= off;
    end
  end

  a_r6_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr) |=> ($stable(bit_cnt) && $stable(err_cnt)));

  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bit_cnt == '0 && err_cnt == '0));

  a_r3_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && din_vld && !clr) |=> ((bit_cnt - $past(bit_cnt) == CNT_W'(8)) || (&bit_cnt)));

  a_r4_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_cnt - $past(err_cnt)) <= CNT_W'(8)));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (bit_cnt >= $past(bit_cnt) && err_cnt >= $past(err_cnt)));

  a_r5_mask_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mask != 8'h00) |-> err_vld);

  a_r7_loss_on_bad_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(din_vld && din != SYNC_BYTE));
endmodule

// File: tb/tb_ts_ref_error_detector.sv
module tb_ts_ref_error_detector;
  localparam int PL = 188;
  localparam int CW = 16;
  localparam int OW = $clog2(PL);

  logic clk = 0, rst_n = 0, clr = 0, din_vld = 0;
  logic [7:0] din = 0;
  logic locked, err_vld;
  logic [CW-1:0] bit_cnt, err_cnt;
  logic [7:0] err_mask;
  logic [OW-1:0] err_off;
  int total = 0, bad = 0;
  bit done = 0;
  longint eb, ee;

  ts_ref_error_detector #(.PKT_LEN(PL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .din(din), .din_vld(din_vld),
    .locked(locked), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
    .err_mask(err_mask), .err_vld(err_vld), .err_off(err_off));

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int i, input int seed);
    logic [7:0] v;
    if (i == 0) return 8'h47;
    v = 8'(i * 29 + seed * 11 + 3);
    if (v == 8'h47) v = 8'h48;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); din = b; din_vld = 1; clr = 0;
  endtask

  task automatic settle();
    @(negedge clk); din_vld = 0; din = 8'h47; clr = 0;
  endtask

  task automatic send(input int seed, input int from, input int to, input int eoff,
                      input logic [7:0] emask, input bit inv, input bit gaps);
    for (int i = from; i <= to; i++) begin
      logic [7:0] b;
      b = pat(i, seed);
      if (inv && i != 0) b = ~b;
      if (i == eoff) b = b ^ emask;
      put(b);
      if (gaps && (i % 7 == 3)) settle();
    end
  endtask

  task automatic t_reset();
    settle();
    chk("R6", "reset locked", locked, 0);
    chk("R6", "reset bit_cnt", bit_cnt, 0);
    chk("R6", "reset err_cnt", err_cnt, 0);
    chk("R5", "reset err_vld", err_vld, 0);
  endtask

  task automatic t_acquire();
    put(8'h00); put(8'h12); put(8'hA5);
    send(1, 0, PL-1, -1, 0, 0, 0); settle();
    chk("R1", "not locked after candidate", locked, 0);
    send(2, 0, PL-1, -1, 0, 0, 0); settle();
    chk("R2", "mismatching packet rejected", locked, 0);
    send(2, 0, PL-1, -1, 0, 0, 1); settle();
    chk("R2", "new candidate not yet locked", locked, 0);
    send(2, 0, PL-1, -1, 0, 0, 1); settle();
    chk("R2", "locked after matching packet", locked, 1);
    chk("R6", "no bits counted before lock", bit_cnt, 0);
    chk("R6", "no errors counted before lock", err_cnt, 0);
  endtask

  task automatic t_clean();
    send(2, 0, PL-1, -1, 0, 0, 1); settle();
    eb = 8 * PL; ee = 0;
    chk("R11", "gapped clean packet bits", bit_cnt, eb);
    chk("R3", "clean packet errors", err_cnt, ee);
  endtask

  task automatic t_errors();
    send(2, 0, 9, -1, 0, 0, 0);
    put(pat(10, 2) ^ 8'h81);
    send(2, 11, 99, -1, 0, 0, 0);
    put(pat(100, 2) ^ 8'hFF);
    settle();
    chk("R5", "err_mask after corrupted byte", err_mask, 8'hFF);
    chk("R5", "err_off after corrupted byte", err_off, 100);
    chk("R5", "err_vld after corrupted byte", err_vld, 1);
    settle();
    chk("R5", "err_vld in idle cycle", err_vld, 0);
    send(2, 101, PL-1, -1, 0, 0, 0); settle();
    eb += 8 * PL; ee += 10;
    chk("R4", "popcount errors", err_cnt, ee);
    chk("R3", "bits after error packet", bit_cnt, eb);
  endtask

  task automatic t_miss_recover();
    send(2, 0, PL-1, 0, 8'h47, 0, 0);
    send(2, 0, PL-1, -1, 0, 0, 0);
    send(2, 0, PL-1, 0, 8'h47, 0, 0);
    send(2, 0, PL-1, -1, 0, 0, 0);
    settle();
    eb += 4 * 8 * PL; ee += 8;
    chk("R7", "good sync resets miss run", locked, 1);
    chk("R7", "missing sync bytes counted", err_cnt, ee);
    chk("R3", "bits over four packets", bit_cnt, eb);
  endtask

  task automatic t_loss();
    send(2, 0, PL-1, 0, 8'h47, 0, 0);
    send(2, 0, PL-1, 0, 8'h47, 0, 0);
    settle();
    chk("R7", "still locked after two misses", locked, 1);
    put(8'h00); settle();
    eb += 2 * 8 * PL + 8; ee += 12;
    chk("R7", "lock lost on third miss", locked, 0);
    chk("R7", "third miss byte counted errors", err_cnt, ee);
    chk("R7", "third miss byte counted bits", bit_cnt, eb);
    send(2, 1, PL-1, -1, 0, 0, 0);
    send(2, 0, PL-1, 3, 8'h01, 0, 0); settle();
    chk("R8", "frozen bits while unlocked", bit_cnt, eb);
    chk("R8", "frozen errors while unlocked", err_cnt, ee);
    chk("R8", "not relocked after candidate", locked, 0);
    send(2, 0, PL-1, 3, 8'h01, 0, 0); settle();
    chk("R8", "relocked after confirmation", locked, 1);
    chk("R8", "bits unchanged by confirmation", bit_cnt, eb);
  endtask

  task automatic t_clear();
    @(negedge clk); clr = 1; din_vld = 0;
    settle();
    chk("R9", "clear bits", bit_cnt, 0);
    chk("R9", "clear errors", err_cnt, 0);
    @(negedge clk); din = pat(0, 2); din_vld = 1; clr = 1;
    send(2, 1, PL-1, 3, 8'h01, 0, 0); settle();
    chk("R9", "clear wins over accepted byte", bit_cnt, 8 * (PL - 1));
    chk("R9", "errors after clear", err_cnt, 0);
  endtask

  task automatic t_sat();
    @(negedge clk); clr = 1; din_vld = 0;
    for (int p = 0; p < 46; p++) send(2, 0, PL-1, 3, 8'h01, 1, 0);
    settle();
    chk("R10", "bit_cnt saturated", bit_cnt, 65535);
    chk("R10", "err_cnt saturated", err_cnt, 65535);
    chk("R10", "lock kept with inverted payload", locked, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_acquire();
    t_clean();
    t_errors();
    t_miss_recover();
    t_loss();
    t_clear();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule